// File: doc/BRIEF.md
# Factory-Image Fallback Sequencer

This controller lives in the factory configuration image of a remotely updatable device. After startup it is told why the factory image was loaded. It then reads two one-bit flags held in serial flash. The selector flag names the preferred application image. The attempt flag records whether a fallback has already been tried since the last clean start.

From these flags and the cause of the load, it updates the attempt flag and chooses one of two outcomes. It either places the boot address of an application image on the reconfiguration port and fires a trigger pulse, or it halts. The attempt flag lives in flash and survives reconfiguration, so when both application images are broken the controller halts on the second failure instead of reconfiguring forever.

Flash access goes through a small command port: one command at a time, each acknowledged by a done pulse, plus a busy line for erase completion. A timeout on every wait sends the sequencer to an error state when the flash stops answering. A status code reports the current phase.

Top module: `rsu_fallback_seq`

## Requirements
- R1: While reset is held and just after it, `seqStatus` is 0 (idle), `flCmdValid` and `rcfgTrigger` are 0, and `rcfgAddr` is 0.
- R2: A `start` pulse in idle issues a read of byte 0x780000 (selector flag) and then a read of byte 0x7C0000 (attempt flag). Command codes on `flCmdOp` are 0 = read, 1 = write, 2 = erase. Status is 1 (reading) from the first read until the decision.
- R3: When `loadCause` is 0 (power-up) or 1 (external reconfiguration pin), the attempt flag is cleared by writing 0xFE to 0x7C0000. The boot address is then 0x280000 (first image) if the selector LSB is 0, and 0x500000 (second image) if it is 1.
- R4: When `loadCause` is 2 (configuration failure) or 3 (watchdog timeout) and the attempt LSB is 0, the sequencer erases the sector at 0x7C0000, waits for done and then for `flBusy` low, and writes 0xFF to 0x7C0000. The boot address is the other image: 0x500000 if the selector LSB is 0, and 0x280000 if it is 1.
- R5: When the cause is 2 or 3 and the attempt LSB is already 1, no write or erase is issued, no trigger is ever raised, and status becomes 4 (stopped).
- R6: A reconfiguration request drives `rcfgAddr` with the boot address for at least one cycle before `rcfgTrigger`. `rcfgTrigger` is then high for exactly one cycle. Status is 3 (reconfiguring) from the address cycle onward.
- R7: `flCmdValid` is a one-cycle pulse, and no command is issued while an earlier one awaits `flDone`. Status is 2 (updating) while the erase or write is in progress.
- R8: A done arriving in the TIMEOUT_CYCLES-th wait cycle after a command is accepted. If done (or, after an erase, busy low) has not arrived by that cycle, status becomes 5 (error), and no further command and no trigger follow.
- R9: `start` is ignored outside idle. The stopped, error and post-trigger states are held until reset.
- R10: Only bit 0 of each flag byte is used; the other seven bits have no effect on the path or the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: begin the sequence |
| loadCause | input | 2 | 0 power-up, 1 pin, 2 configuration failure, 3 watchdog |
| flCmdValid | output | 1 | Flash command strobe |
| flCmdOp | output | 2 | 0 read, 1 write, 2 erase |
| flAddr | output | 24 | Flash byte or sector address |
| flWrData | output | 8 | Byte to program |
| flBusy | input | 1 | Flash operation in progress |
| flDone | input | 1 | Command completion pulse |
| flRdData | input | 8 | Read byte, valid with flDone |
| rcfgAddr | output | 24 | Boot address for reconfiguration |
| rcfgTrigger | output | 1 | One-cycle reconfiguration request |
| seqStatus | output | 3 | 0 idle, 1 reading, 2 updating, 3 reconfiguring, 4 stopped, 5 error |

## Verification
Two events can fall in the same cycle: the flash completion pulse and the expiry of the wait timeout. When they coincide, completion must win. The bench's flash model takes a response delay. Setting that delay to exactly TIMEOUT_CYCLES puts done on the final allowed wait cycle, and the run must then finish with a normal reconfiguration. One cycle more must end in the error status after a single command. A separate run keeps busy high past the limit after an erase, and must stop with error before the write is issued.

// File: rtl/rsu_fb_pkg.sv
package rsu_fb_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2
  } flOp_e;

  typedef enum logic [2:0] {
    STAT_IDLE     = 3'd0,
    STAT_READING  = 3'd1,
    STAT_UPDATING = 3'd2,
    STAT_RECONFIG = 3'd3,
    STAT_STOPPED  = 3'd4,
    STAT_ERROR    = 3'd5
  } seqStat_e;

  typedef enum logic [1:0] {
    SEL_RD_PAGE  = 2'd0,
    SEL_RD_RETRY = 2'd1,
    SEL_ERASE    = 2'd2,
    SEL_WR_RETRY = 2'd3
  } cmdSel_e;

  typedef struct packed {
    logic    latchCause;
    logic    latchPage;
    logic    latchRetry;
    logic    timerClr;
    logic    timerInc;
    logic    issue;
    cmdSel_e cmdSel;
    logic    loadTarget;
  } ctrlStrobe_t;

endpackage

// File: rtl/rsu_fb_datapath.sv
module rsu_fb_datapath
  import rsu_fb_pkg::*;
#(
  parameter int          ADDR_W         = 24,
  parameter int          DATA_W         = 8,
  parameter int          TIMEOUT_CYCLES = 4096,
  parameter logic [23:0] PAGE_ADDR      = 24'h780000,
  parameter logic [23:0] RETRY_ADDR     = 24'h7C0000,
  parameter logic [23:0] IMG1_BASE      = 24'h280000,
  parameter logic [23:0] IMG2_BASE      = 24'h500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [1:0]        loadCause,
  input  logic [DATA_W-1:0] flRdData,
  output logic              causeFail,
  output logic              pageBit,
  output logic              retryBit,
  output logic              timerExpired,
  output logic [1:0]        flCmdOp,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWrData,
  output logic [ADDR_W-1:0] rcfgAddr
);

  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYCLES - 1);
  localparam logic [DATA_W-1:0] BYTE_SET   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] BYTE_CLEAR = {{(DATA_W-1){1'b1}}, 1'b0};

  logic [1:0]       causeQ;
  logic [TMR_W-1:0] waitTimer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ   <= 2'd0;
      pageBit  <= 1'b0;
      retryBit <= 1'b0;
      rcfgAddr <= '0;
    end else begin
      if (strb.latchCause) causeQ   <= loadCause;
      if (strb.latchPage)  pageBit  <= flRdData[0];
      if (strb.latchRetry) retryBit <= flRdData[0];
      if (strb.loadTarget) begin
        // a failure boots the other image, a clean start the selected one
        if (pageBit ^ causeFail) rcfgAddr <= ADDR_W'(IMG2_BASE);
        else                     rcfgAddr <= ADDR_W'(IMG1_BASE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              waitTimer <= '0;
    else if (strb.timerClr) waitTimer <= '0;
    else if (strb.timerInc) waitTimer <= waitTimer + 1'b1;
  end

  assign causeFail    = causeQ[1];
  assign timerExpired = (waitTimer == TMR_LAST);

  always_comb begin
    flWrData = '0;
    unique case (strb.cmdSel)
      SEL_RD_PAGE: begin
        flCmdOp = OP_READ;
        flAddr  = ADDR_W'(PAGE_ADDR);
      end
      SEL_RD_RETRY: begin
        flCmdOp = OP_READ;
        flAddr  = ADDR_W'(RETRY_ADDR);
      end
      SEL_ERASE: begin
        flCmdOp = OP_ERASE;
        flAddr  = ADDR_W'(RETRY_ADDR);
      end
      default: begin
        flCmdOp  = OP_WRITE;
        flAddr   = ADDR_W'(RETRY_ADDR);
        flWrData = causeFail ? BYTE_SET : BYTE_CLEAR;
      end
    endcase
  end

  // R8: the wait counter never runs past its limit
  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitTimer <= TMR_LAST);

  // R6: a new boot address is only loaded on the strobe
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadTarget) |-> $stable(rcfgAddr));

endmodule

// File: rtl/rsu_fb_control.sv
module rsu_fb_control
  import rsu_fb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        flDone,
  input  logic        flBusy,
  input  logic        causeFail,
  input  logic        retryBit,
  input  logic        timerExpired,
  output ctrlStrobe_t strb,
  output logic        rcfgTrigger,
  output logic [2:0]  seqStatus
);

  typedef enum logic [3:0] {
    S_IDLE, S_RDP_ISSUE, S_RDP_WAIT, S_RDR_ISSUE, S_RDR_WAIT, S_DECIDE,
    S_ER_ISSUE, S_ER_WAIT, S_ER_BUSY, S_WR_ISSUE, S_WR_WAIT,
    S_RC_SETUP, S_RC_FIRE, S_RC_HOLD, S_STOP, S_ERR
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.latchCause = 1'b1;
        stateNxt        = S_RDP_ISSUE;
      end
      S_RDP_ISSUE: begin
        strb.issue    = 1'b1;
        strb.cmdSel   = SEL_RD_PAGE;
        strb.timerClr = 1'b1;
        stateNxt      = S_RDP_WAIT;
      end
      S_RDP_WAIT: begin
        if (flDone) begin
          strb.latchPage = 1'b1;
          stateNxt       = S_RDR_ISSUE;
        end else if (timerExpired) stateNxt = S_ERR;
        else strb.timerInc = 1'b1;
      end
      S_RDR_ISSUE: begin
        strb.issue    = 1'b1;
        strb.cmdSel   = SEL_RD_RETRY;
        strb.timerClr = 1'b1;
        stateNxt      = S_RDR_WAIT;
      end
      S_RDR_WAIT: begin
        if (flDone) begin
          strb.latchRetry = 1'b1;
          stateNxt        = S_DECIDE;
        end else if (timerExpired) stateNxt = S_ERR;
        else strb.timerInc = 1'b1;
      end
      S_DECIDE: begin
        if (!causeFail)    stateNxt = S_WR_ISSUE;
        else if (retryBit) stateNxt = S_STOP;
        else               stateNxt = S_ER_ISSUE;
      end
      S_ER_ISSUE: begin
        strb.issue    = 1'b1;
        strb.cmdSel   = SEL_ERASE;
        strb.timerClr = 1'b1;
        stateNxt      = S_ER_WAIT;
      end
      S_ER_WAIT: begin
        strb.cmdSel = SEL_ERASE;
        if (flDone) begin
          strb.timerClr = 1'b1;
          stateNxt      = S_ER_BUSY;
        end else if (timerExpired) stateNxt = S_ERR;
        else strb.timerInc = 1'b1;
      end
      S_ER_BUSY: begin
        strb.cmdSel = SEL_ERASE;
        if (!flBusy)            stateNxt = S_WR_ISSUE;
        else if (timerExpired)  stateNxt = S_ERR;
        else strb.timerInc = 1'b1;
      end
      S_WR_ISSUE: begin
        strb.issue    = 1'b1;
        strb.cmdSel   = SEL_WR_RETRY;
        strb.timerClr = 1'b1;
        stateNxt      = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        strb.cmdSel = SEL_WR_RETRY;
        if (flDone) begin
          strb.loadTarget = 1'b1;
          stateNxt        = S_RC_SETUP;
        end else if (timerExpired) stateNxt = S_ERR;
        else strb.timerInc = 1'b1;
      end
      S_RC_SETUP: stateNxt = S_RC_FIRE;
      S_RC_FIRE:  stateNxt = S_RC_HOLD;
      default: ;
    endcase
  end

  assign rcfgTrigger = (state == S_RC_FIRE);

  always_comb begin
    unique case (state)
      S_IDLE:                                      seqStatus = STAT_IDLE;
      S_RDP_ISSUE, S_RDP_WAIT, S_RDR_ISSUE,
      S_RDR_WAIT, S_DECIDE:                        seqStatus = STAT_READING;
      S_ER_ISSUE, S_ER_WAIT, S_ER_BUSY,
      S_WR_ISSUE, S_WR_WAIT:                       seqStatus = STAT_UPDATING;
      S_RC_SETUP, S_RC_FIRE, S_RC_HOLD:            seqStatus = STAT_RECONFIG;
      S_STOP:                                      seqStatus = STAT_STOPPED;
      default:                                     seqStatus = STAT_ERROR;
    endcase
  end

  // R7: a command strobe lasts one cycle and is followed by a wait
  assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> !strb.issue);

  // R6: trigger is a single-cycle pulse
  assert_trig_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rcfgTrigger |=> !rcfgTrigger);

  // R5: stopped state is silent and sticky
  assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STOP) |=> (state == S_STOP) && !strb.issue && !rcfgTrigger);

  // R8: error state is silent and sticky
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ERR) |=> (state == S_ERR) && !strb.issue && !rcfgTrigger);

  // R4: the write after an erase only follows busy going low
  assert_busy_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ER_BUSY && flBusy) |=> (state != S_WR_ISSUE));

endmodule

// File: rtl/rsu_fallback_seq.sv
module rsu_fallback_seq
  import rsu_fb_pkg::*;
#(
  parameter int          ADDR_W         = 24,
  parameter int          DATA_W         = 8,
  parameter int          TIMEOUT_CYCLES = 4096,
  parameter logic [23:0] PAGE_ADDR      = 24'h780000,
  parameter logic [23:0] RETRY_ADDR     = 24'h7C0000,
  parameter logic [23:0] IMG1_BASE      = 24'h280000,
  parameter logic [23:0] IMG2_BASE      = 24'h500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        loadCause,
  output logic              flCmdValid,
  output logic [1:0]        flCmdOp,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWrData,
  input  logic              flBusy,
  input  logic              flDone,
  input  logic [DATA_W-1:0] flRdData,
  output logic [ADDR_W-1:0] rcfgAddr,
  output logic              rcfgTrigger,
  output logic [2:0]        seqStatus
);

  ctrlStrobe_t strb;
  logic causeFail, pageBit, retryBit, timerExpired;

  rsu_fb_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .flDone       (flDone),
    .flBusy       (flBusy),
    .causeFail    (causeFail),
    .retryBit     (retryBit),
    .timerExpired (timerExpired),
    .strb         (strb),
    .rcfgTrigger  (rcfgTrigger),
    .seqStatus    (seqStatus)
  );

  rsu_fb_datapath #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .PAGE_ADDR      (PAGE_ADDR),
    .RETRY_ADDR     (RETRY_ADDR),
    .IMG1_BASE      (IMG1_BASE),
    .IMG2_BASE      (IMG2_BASE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .loadCause    (loadCause),
    .flRdData     (flRdData),
    .causeFail    (causeFail),
    .pageBit      (pageBit),
    .retryBit     (retryBit),
    .timerExpired (timerExpired),
    .flCmdOp      (flCmdOp),
    .flAddr       (flAddr),
    .flWrData     (flWrData),
    .rcfgAddr     (rcfgAddr)
  );

  assign flCmdValid = strb.issue;

  // R6: boot address steady on the trigger cycle, trigger only while reconfiguring
  assert_trig_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    rcfgTrigger |-> $stable(rcfgAddr) && (seqStatus == 3'd3));

  // R2: every command targets one of the two flag bytes
  assert_cmd_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    flCmdValid |-> (flAddr == ADDR_W'(PAGE_ADDR)) || (flAddr == ADDR_W'(RETRY_ADDR)));

endmodule

// File: tb/rsu_fallback_seq_tb.sv
module rsu_fallback_seq_tb;

  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  loadCause = 2'd0;
  logic        flCmdValid;
  logic [1:0]  flCmdOp;
  logic [23:0] flAddr;
  logic [7:0]  flWrData;
  logic        flBusy = 1'b0;
  logic        flDone = 1'b0;
  logic [7:0]  flRdData = 8'h00;
  logic [23:0] rcfgAddr;
  logic        rcfgTrigger;
  logic [2:0]  seqStatus;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  rsu_fallback_seq #(.TIMEOUT_CYCLES(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .loadCause(loadCause),
    .flCmdValid(flCmdValid), .flCmdOp(flCmdOp), .flAddr(flAddr),
    .flWrData(flWrData), .flBusy(flBusy), .flDone(flDone),
    .flRdData(flRdData), .rcfgAddr(rcfgAddr), .rcfgTrigger(rcfgTrigger),
    .seqStatus(seqStatus)
  );

  // flash model and reference state
  logic [7:0]  memPage, memRetry;
  int          doneDelay, busyTail;
  int          expOp[$];
  logic [23:0] expAddr[$];
  logic [7:0]  expData[$];
  int          trigCount;
  logic [23:0] prevAddr, trigAddr;
  bit          active, inDone;
  int          cnt, tailCnt, curOp;
  logic [23:0] curAddr;
  logic [7:0]  curData;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    active = 0; inDone = 0; tailCnt = 0; trigCount = 0; prevAddr = '0;
    forever begin
      @(negedge clk);
      if (inDone) begin
        flDone = 1'b0; inDone = 0;
        if (curOp == 2 && busyTail > 0) tailCnt = busyTail;
        else flBusy = 1'b0;
      end else if (tailCnt > 0) begin
        tailCnt--;
        if (tailCnt == 0) flBusy = 1'b0;
      end
      if (active) begin
        cnt++;
        if (cnt == doneDelay) begin
          active = 0; inDone = 1; flDone = 1'b1;
          if (curOp == 0) flRdData = (curAddr == 24'h780000) ? memPage : memRetry;
          else if (curOp == 1) memRetry = memRetry & curData;
          else memRetry = 8'hFF;
        end
      end
      if (rstN && flCmdValid) begin
        if (expOp.size() == 0) begin
          check(0, "R7/R9", "unexpected command op", flCmdOp, 0);
        end else begin
          int eo; logic [23:0] ea; logic [7:0] ed;
          eo = expOp.pop_front(); ea = expAddr.pop_front(); ed = expData.pop_front();
          check(flCmdOp == 2'(eo), "R2", "command op", flCmdOp, eo);
          check(flAddr == ea, "R2", "command addr", flAddr, ea);
          if (eo == 1) check(flWrData == ed, "R3/R4", "write data", flWrData, ed);
        end
        active = 1; cnt = 0; flBusy = 1'b1;
        curOp = int'(flCmdOp); curAddr = flAddr; curData = flWrData;
      end
      if (rstN && rcfgTrigger) begin
        trigCount++; trigAddr = rcfgAddr;
        check(rcfgAddr == prevAddr, "R6", "address held before trigger", rcfgAddr, prevAddr);
        check(seqStatus == 3'd3, "R6", "status at trigger", seqStatus, 3);
      end
      prevAddr = rcfgAddr;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic do_reset();
    rstN = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    check(seqStatus == 3'd0, "R1", "status in reset", seqStatus, 0);
    check(!flCmdValid && !rcfgTrigger, "R1", "strobes in reset", {flCmdValid, rcfgTrigger}, 0);
    check(rcfgAddr == 24'h0, "R1", "address in reset", rcfgAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(seqStatus == 3'd0, "R1", "status after reset", seqStatus, 0);
  endtask

  task automatic push(input int op, input logic [23:0] a, input logic [7:0] d);
    expOp.push_back(op); expAddr.push_back(a); expData.push_back(d);
  endtask

  // mode: 0 normal, 1 read times out, 2 erase busy times out
  task automatic run_case(input string name, input logic [1:0] cause,
                          input logic [7:0] pg, input logic [7:0] rt,
                          input int dly, input int tail, input int mode);
    logic fail, expStop;
    logic [23:0] expBoot;
    logic expRetryLsb;
    int expStat, expTrig;
    int seenUpd;
    memPage = pg; memRetry = rt; doneDelay = dly; busyTail = tail;
    expOp.delete(); expAddr.delete(); expData.delete();
    active = 0; inDone = 0; tailCnt = 0; flDone = 0; flBusy = 0;
    do_reset();
    trigCount = 0;
    fail = cause[1];
    push(0, 24'h780000, 8'h00);
    if (mode != 1) push(0, 24'h7C0000, 8'h00);
    expStop = fail && rt[0];
    expRetryLsb = rt[0];
    expBoot = '0;
    if (mode == 1) begin
      expStat = 5; expTrig = 0;
    end else if (!fail) begin
      push(1, 24'h7C0000, 8'hFE); expRetryLsb = 1'b0;
      expBoot = pg[0] ? 24'h500000 : 24'h280000; expStat = 3; expTrig = 1;
    end else if (expStop) begin
      expStat = 4; expTrig = 0;
    end else begin
      push(2, 24'h7C0000, 8'h00);
      if (mode == 2) begin
        expStat = 5; expTrig = 0; expRetryLsb = 1'b1;
      end else begin
        push(1, 24'h7C0000, 8'hFF); expRetryLsb = 1'b1;
        expBoot = pg[0] ? 24'h280000 : 24'h500000; expStat = 3; expTrig = 1;
      end
    end
    loadCause = cause; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(seqStatus == 3'd1, "R2", {name, " status reading"}, seqStatus, 1);
    seenUpd = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (seqStatus == 3'd2) seenUpd = 1;
      if (seqStatus == 3'd4 || seqStatus == 3'd5 ||
          (seqStatus == 3'd3 && trigCount > 0)) break;
    end
    repeat (4) @(negedge clk);
    check(int'(seqStatus) == expStat, expStop ? "R5" : (mode != 0 ? "R8" : "R3/R4"),
          {name, " final status"}, seqStatus, expStat);
    check(trigCount == expTrig, "R6", {name, " trigger count"}, trigCount, expTrig);
    if (expTrig == 1)
      check(trigAddr == expBoot, fail ? "R4" : "R3", {name, " boot address"}, trigAddr, expBoot);
    check(expOp.size() == 0, "R7", {name, " commands outstanding"}, expOp.size(), 0);
    check(memRetry[0] == expRetryLsb, fail ? "R4" : "R3", {name, " attempt flag"}, memRetry[0], expRetryLsb);
    if (expStat == 3)
      check(seenUpd == 1, "R7", {name, " updating status seen"}, seenUpd, 1);
    // R9: start in a terminal state has no effect
    loadCause = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * TMO) @(negedge clk);
    check(int'(seqStatus) == expStat, "R9", {name, " start ignored"}, seqStatus, expStat);
    check(trigCount == expTrig, "R9", {name, " no extra trigger"}, trigCount, expTrig);
  endtask

  initial begin
    run_case("power page0",   2'd0, 8'hFE, 8'hFF, 2, 0, 0);    // R3
    run_case("pin page1",     2'd1, 8'h01, 8'h00, 1, 0, 0);    // R3
    run_case("fail page0",    2'd2, 8'h00, 8'h00, 3, 3, 0);    // R4
    run_case("wdog page1",    2'd3, 8'h57, 8'hA2, 2, 5, 0);    // R4, R10
    run_case("fail retry1",   2'd2, 8'h00, 8'h01, 2, 0, 0);    // R5
    run_case("wdog retry1",   2'd3, 8'hFF, 8'hFF, 1, 0, 0);    // R5, R10
    run_case("done at limit", 2'd0, 8'h00, 8'hFF, TMO, 0, 0);  // R8 boundary accepted
    run_case("done late",     2'd0, 8'h00, 8'hFF, TMO + 1, 0, 1); // R8 timeout
    run_case("busy stuck",    2'd2, 8'h01, 8'h00, 2, TMO + 20, 2); // R8 erase busy
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule